// File: doc/BRIEF.md
# Switchable Address Window Translator

This block sits between a peripheral port and a 24-bit target address space. Every peripheral access that lands in its window carries a 16-bit displacement. The block adds that displacement to a 24-bit base register to form a target address, and the sum wraps modulo 2^24. A mode bit then sends the access to one of two spaces. In memory mode it goes out on a memory request port. In register mode it goes to a small internal file of 16-bit registers, one at each even address.

A separate control port writes the mode bit and the base register. In register mode, address 0 returns a fixed processor identity value and ignores writes. Address 2 is the interprocessor message register, and writing it raises an event pulse. The higher even addresses hold general-purpose words for things such as configuration or error logs. A register-mode access is refused with an error pulse if it is byte-wide, if its address is odd, or if its address lies past the end of the file.

Top module: `win_xlate`

## Requirements
- R1: After reset the block is in memory mode with base 0. `mem_req`, `per_ack`, `per_err` and `ipc_event` are all low.
- R2: In memory mode, a request on `per_req` gives `mem_req` high in the next cycle. In that cycle `mem_addr` is base + displacement, and `mem_we`, `mem_wdata` and `mem_word` are copies of the request's fields. `per_ack` pulses in the same cycle.
- R3: The target address is (base + zero-extended displacement) mod 2^24.
- R4: For a memory-mode read, `per_rdata` equals `mem_rdata` in the cycle in which `per_ack` is high.
- R5: A control write (`cfg_sel`=0 sets the mode from `cfg_wdata[0]`, where 1 selects register mode; `cfg_sel`=1 sets the base) affects only accesses issued in later cycles. An access issued in the same cycle as the write uses the old settings.
- R6: In register mode, a read of address 0 returns `PROC_ID`. A write to address 0 is acknowledged and leaves the value unchanged.
- R7: In register mode, word accesses to the even addresses 2 to 2*NREG-2 write or read the register at index address/2. The read value appears on `per_rdata` together with `per_ack`, one cycle after the request. No `mem_req` is raised.
- R8: In register mode, an access that is byte-wide (`per_word`=0) or whose address is odd gives `per_err` instead of `per_ack`. It changes no register and raises no `ipc_event`.
- R9: In register mode, an address of 2*NREG or above gives `per_err` and changes no register.
- R10: An accepted register-mode write to address 2 gives a one-cycle `ipc_event` pulse in the next cycle, and the register then holds the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_sel | input | 1 | 0: mode bit, 1: base register |
| cfg_wdata | input | 24 | Control write data |
| per_req | input | 1 | Peripheral access strobe |
| per_we | input | 1 | 1 = write |
| per_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| per_disp | input | 16 | Displacement within the window |
| per_wdata | input | 16 | Write data |
| per_rdata | output | 16 | Read data, valid with per_ack |
| per_ack | output | 1 | Access completed |
| per_err | output | 1 | Access refused |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_word | output | 1 | Memory access width |
| mem_addr | output | 24 | Translated address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, same cycle as mem_req |
| ipc_event | output | 1 | Message register written |

## Verification
The bench drives a base near 2^24 with a large displacement. A design that drops the carry badly, or sign-extends the displacement, would put out a wrong `mem_addr`. It issues a control write and an access in the same cycle; a design that forwards the new mode or base early would route or translate that access wrongly. In register mode it sends odd, byte-wide and out-of-range accesses, and a design that lets any of them through would corrupt a register or pulse `ipc_event`. It also writes address 0, which must still read back the identity value afterwards.

// File: rtl/win_xlate.sv
module win_xlate #(
  parameter int ADDR_W = 24,
  parameter int DISP_W = 16,
  parameter int DATA_W = 16,
  parameter int NREG = 16,
  parameter logic [DATA_W-1:0] PROC_ID = 'h5A17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              per_req,
  input  logic              per_we,
  input  logic              per_word,
  input  logic [DISP_W-1:0] per_disp,
  input  logic [DATA_W-1:0] per_wdata,
  output logic [DATA_W-1:0] per_rdata,
  output logic              per_ack,
  output logic              per_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_word,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ipc_event
);
  localparam int IDX_W = $clog2(NREG);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(2 * NREG);

  logic              mode_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] rd_q;
  logic              mem_rd_q;

  wire [ADDR_W-1:0] tgt     = base_q + ADDR_W'(per_disp);
  wire [IDX_W-1:0]  idx     = tgt[IDX_W:1];
  wire              icr_bad = !per_word || tgt[0] || (tgt >= SPAN);
  wire              icr_go  = per_req && mode_q && !icr_bad;
  wire              icr_wr  = icr_go && per_we && (idx != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      base_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) base_q <= cfg_wdata;
      else         mode_q <= cfg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (icr_wr) begin
      regs[idx] <= per_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_ack   <= 1'b0;
      per_err   <= 1'b0;
      ipc_event <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_word  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_rd_q  <= 1'b0;
      rd_q      <= '0;
    end else begin
      per_ack   <= per_req && (!mode_q || !icr_bad);
      per_err   <= per_req && mode_q && icr_bad;
      ipc_event <= icr_go && per_we && (idx == IDX_W'(1));
      mem_req   <= per_req && !mode_q;
      mem_we    <= per_req && !mode_q && per_we;
      mem_rd_q  <= per_req && !mode_q && !per_we;
      if (per_req && !mode_q) begin
        mem_word  <= per_word;
        mem_addr  <= tgt;
        mem_wdata <= per_wdata;
      end
      if (icr_go && !per_we) rd_q <= (idx == '0) ? PROC_ID : regs[idx];
    end
  end

  assign per_rdata = mem_rd_q ? mem_rdata : rd_q;
endmodule

// File: rtl/win_xlate_chk.sv
module win_xlate_chk #(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] PROC_ID = 'h5A17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_q,
  input logic              per_req,
  input logic              per_we,
  input logic              per_word,
  input logic              per_ack,
  input logic              per_err,
  input logic              mem_req,
  input logic              ipc_event,
  input logic [15:0]       per_disp,
  input logic [23:0]       base_q,
  input logic [DATA_W-1:0] per_rdata
);
  a_r2_mem_follows: assert property (@(posedge clk) disable iff (!rst_n)
    per_req && !mode_q |=> mem_req && per_ack);
  a_r2_mem_cause: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $past(per_req) && !$past(mode_q));
  a_r7_no_mem_in_reg: assert property (@(posedge clk) disable iff (!rst_n)
    per_req && mode_q |=> !mem_req);
  a_r8_ack_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(per_ack && per_err));
  a_r8_byte_refused: assert property (@(posedge clk) disable iff (!rst_n)
    per_req && mode_q && !per_word |=> per_err && !ipc_event);
  a_r10_ipc_acked: assert property (@(posedge clk) disable iff (!rst_n)
    ipc_event |-> per_ack && !mem_req);
  a_r6_id_read: assert property (@(posedge clk) disable iff (!rst_n)
    per_req && mode_q && per_word && !per_we && (base_q + 24'(per_disp)) == 24'd0
    |=> per_rdata == PROC_ID);
endmodule

bind win_xlate win_xlate_chk #(.DATA_W(DATA_W), .PROC_ID(PROC_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .per_req(per_req), .per_we(per_we),
  .per_word(per_word), .per_ack(per_ack), .per_err(per_err), .mem_req(mem_req),
  .ipc_event(ipc_event), .per_disp(per_disp), .base_q(base_q), .per_rdata(per_rdata)
);

// File: tb/win_xlate_tb.sv
module win_xlate_tb;
  localparam int NREG = 16;
  localparam logic [15:0] PID = 16'h5A17;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [23:0] cfg_wdata = '0;
  logic per_req = 0, per_we = 0, per_word = 1;
  logic [15:0] per_disp = '0, per_wdata = '0;
  logic [15:0] per_rdata, mem_wdata, mem_rdata;
  logic per_ack, per_err, mem_req, mem_we, mem_word, ipc_event;
  logic [23:0] mem_addr;

  int n_run = 0, n_fail = 0;
  logic m_mode;
  logic [23:0] m_base;
  logic [15:0] m_regs [NREG];

  always #2 clk = ~clk;

  assign mem_rdata = mem_addr[15:0] ^ 16'hA5C3;

  win_xlate #(.NREG(NREG), .PROC_ID(PID)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .per_req(per_req), .per_we(per_we), .per_word(per_word), .per_disp(per_disp),
    .per_wdata(per_wdata), .per_rdata(per_rdata), .per_ack(per_ack), .per_err(per_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ipc_event(ipc_event)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] xl(input logic [23:0] b, input logic [15:0] d);
    return b + {8'h00, d};
  endfunction

  function automatic logic bad(input logic [23:0] a, input logic w);
    return !w || a[0] || (a >= 24'(2 * NREG));
  endfunction

  task automatic cfg(input logic sel, input logic [23:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    if (sel) m_base = v; else m_mode = v[0];
  endtask

  task automatic access(input logic we, input logic word, input logic [15:0] d,
                        input logic [15:0] wd, input string tag);
    logic [23:0] a;
    logic b;
    a = xl(m_base, d);
    b = bad(a, word);
    @(negedge clk);
    per_req = 1; per_we = we; per_word = word; per_disp = d; per_wdata = wd;
    @(negedge clk);
    per_req = 0;
    if (!m_mode) begin
      chk({tag, " R2 mem_req"}, {31'd0, mem_req}, 1);
      chk({tag, " R3 mem_addr"}, {8'd0, mem_addr}, {8'd0, a});
      chk({tag, " R2 fields"}, {14'd0, mem_we, mem_word, mem_wdata}, {14'd0, we, word, wd});
      chk({tag, " R2 ack"}, {30'd0, per_ack, per_err}, 2);
      if (!we) chk({tag, " R4 rdata"}, {16'd0, per_rdata}, {16'd0, a[15:0] ^ 16'hA5C3});
    end else begin
      chk({tag, " R7 no mem_req"}, {31'd0, mem_req}, 0);
      chk({tag, " R8/R9 ack/err"}, {30'd0, per_ack, per_err}, b ? 2'b01 : 2'b10);
      chk({tag, " R10 ipc_event"}, {31'd0, ipc_event}, {31'd0, !b && we && a[23:1] == 23'd1});
      if (!b && !we)
        chk({tag, " R6/R7 rdata"}, {16'd0, per_rdata},
            {16'd0, (a == 0) ? PID : m_regs[a[4:1]]});
      if (!b && we && a != 0) m_regs[a[4:1]] = wd;
    end
    if (ipc_event) begin
      @(negedge clk);
      chk({tag, " R10 pulse width"}, {31'd0, ipc_event}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_mode = 0; m_base = 0;
    for (int i = 0; i < NREG; i++) m_regs[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {28'd0, mem_req, per_ack, per_err, ipc_event}, 0);
    rst_n = 1;
    access(0, 1, 16'h1234, 0, "r1_base0");
    cfg(1, 24'hFFFF00);
    access(1, 1, 16'h0345, 16'hBEEF, "r3_wrap");
    access(0, 0, 16'hFFFF, 0, "r3_wrap2");
    // R5: mode write and access in the same cycle use the old mode
    @(negedge clk);
    cfg_we = 1; cfg_sel = 0; cfg_wdata = 24'd1;
    per_req = 1; per_we = 0; per_word = 1; per_disp = 16'h0010;
    @(negedge clk);
    cfg_we = 0; per_req = 0;
    chk("R5 same-cycle old mode", {31'd0, mem_req}, 1);
    chk("R5 same-cycle old addr", {8'd0, mem_addr}, {8'd0, xl(24'hFFFF00, 16'h0010)});
    m_mode = 1;
    cfg(1, 24'd0);
    access(0, 1, 0, 0, "r6_id");
    access(1, 1, 0, 16'h1111, "r6_idwr");
    access(0, 1, 0, 0, "r6_idkeep");
    access(1, 1, 2, 16'hCAFE, "r10_ipc");
    access(0, 1, 2, 0, "r10_ipcrd");
    access(1, 1, 6, 16'h7777, "r7_gp");
    access(1, 1, 7, 16'h0BAD, "r8_odd");
    access(1, 0, 6, 16'h0BAD, "r8_byte");
    access(0, 1, 6, 0, "r8_keep");
    access(1, 1, 16'(2 * NREG), 16'h0BAD, "r9_range");
    access(0, 1, 16'(2 * NREG - 2), 0, "r9_last");
    for (int k = 0; k < 400; k++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) cfg(0, {23'd0, 1'($urandom_range(0, 1))});
      else if (r == 1) cfg(1, ($urandom_range(0, 1) == 1) ? 24'($urandom) : 24'($urandom_range(0, 40)));
      else access(1'($urandom_range(0, 1)), ($urandom_range(0, 5) != 0),
                  m_mode ? 16'($urandom_range(0, 40)) : 16'($urandom),
                  16'($urandom), "rand");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule